// File: doc/BRIEF.md
# Multi-format serial audio receiver

This block takes stereo PCM from a three-wire serial audio link on which it is always the receiving end. The three wires are a bit clock, a left/right frame clock and serial data. The block runs on a faster system clock. It brings the three wires into that domain and takes one data bit on every rising edge of the bit clock. A three-bit format code chooses one of five framings: right-justified at 16, 20 or 24 bits, left-justified at 20 bits, or I2S with a 16- or 20-bit word. In every framing the word is sent in two's complement with its most significant bit first.

For each complete frame, the block presents a left and a right sample, each sign-extended to 24 bits, together with a valid strobe one system cycle wide. It also reports whether the number of bit clocks in that frame matches the number the selected format expects. The format code is captured while reset is held and stays fixed until the next reset.

Top module: `serial_audio_rx`

## Requirements
- R1: While `rst_n` is low, `pcm_left`, `pcm_right`, `pcm_valid` and `frame_err` are all 0.
- R2: The format code on `fmt_sel` is captured on the last system clock edge before `rst_n` rises. Changes to `fmt_sel` after that have no effect on the decoded samples until the next reset.
- R3: Code 0: 16-bit right-justified, 32 bit clocks per frame. The left word is sent while the frame clock is high. The word's LSB is the last bit before the frame-clock edge. The output is the word sign-extended from bit 15.
- R4: Code 1: 20-bit right-justified, 40 bit clocks per frame, left while the frame clock is high. The output is sign-extended from bit 19.
- R5: Code 2: 20-bit left-justified. The MSB is the first bit taken at the frame-clock edge, the left word is sent while the frame clock is high, and any bits after the 20th in a half-frame are ignored.
- R6: Code 3: I2S. The MSB comes one bit clock after the frame-clock edge, and the left word is sent while the frame clock is low. The word is 16 bits when the half-frame lasts 16 bit clocks and 20 bits when it lasts 20.
- R7: Code 4: 24-bit right-justified, 48 bit clocks per frame, left while the frame clock is high. Codes 5, 6 and 7 decode exactly as code 4.
- R8: In right-justified codes, bits that arrive in a half-frame before the word are ignored.
- R9: `pcm_valid` pulses for one cycle per frame. It pulses no later than 6 system cycles after the bit-clock rise that ends the right half-frame. Between strobes, `pcm_left`, `pcm_right` and `frame_err` hold their values.
- R10: `frame_err` is loaded with each strobe. It is 1 when the frame's bit-clock count differs from the expected count: 32 for code 0, 40 for codes 1 and 2, 32 or 40 for code 3, and 48 otherwise.
- R11: A half-frame that did not start at a frame-clock edge seen after reset is discarded. A right half with no complete left half before it produces no strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the bit clock |
| rst_n | input | 1 | Active-low reset; `fmt_sel` is captured while it is low |
| fmt_sel | input | 3 | Framing code 0..7 |
| bck | input | 1 | Serial bit clock |
| lrck | input | 1 | Left/right frame clock |
| sdin | input | 1 | Serial data |
| pcm_left | output | 24 | Sign-extended left sample |
| pcm_right | output | 24 | Sign-extended right sample |
| pcm_valid | output | 1 | One-cycle strobe when a new pair is presented |
| frame_err | output | 1 | The last frame's bit-clock count did not match the format |

## Verification
The properties assume a slow bit clock: each of its phases must last at least three system cycles. They also assume that the frame clock and data change only near a falling bit-clock edge, so that every rising edge is seen exactly once, with settled values behind it. The stimulus keeps each bit-clock phase at four system cycles and changes the frame clock and data together with the falling edge. The properties also rely on the fact that every half-frame spans several bit clocks, so two strobes can never fall in adjacent cycles.

// File: rtl/srx_pkg.sv
package srx_pkg;
  localparam int SAMPLE_W = 24;
  localparam int CNT_W    = 6;

  localparam logic [2:0] FMT_RJ16 = 3'd0;
  localparam logic [2:0] FMT_RJ20 = 3'd1;
  localparam logic [2:0] FMT_LJ20 = 3'd2;
  localparam logic [2:0] FMT_I2S  = 3'd3;

  // word width for a format and a measured half-frame length
  function automatic int word_bits(input logic [2:0] fmt, input logic [CNT_W-1:0] half_len);
    case (fmt)
      FMT_RJ16:           return 16;
      FMT_RJ20, FMT_LJ20: return 20;
      FMT_I2S:            return (half_len <= 16) ? 16 : 20;
      default:            return SAMPLE_W;
    endcase
  endfunction

  // frame length check against the format's expected bit-clock count
  function automatic logic frame_len_ok(input logic [2:0] fmt, input logic [CNT_W:0] total);
    case (fmt)
      FMT_RJ16:           return total == 7'd32;
      FMT_RJ20, FMT_LJ20: return total == 7'd40;
      FMT_I2S:            return (total == 7'd32) || (total == 7'd40);
      default:            return total == 7'd48;
    endcase
  endfunction

  // keep the low `bits` bits and replicate the top one upward
  function automatic logic [SAMPLE_W-1:0] sign_fill(input logic [SAMPLE_W-1:0] raw, input int bits);
    logic signed [SAMPLE_W-1:0] t;
    t = $signed(raw << (SAMPLE_W - bits));
    return $unsigned(t >>> (SAMPLE_W - bits));
  endfunction

  // choose the word out of the shift history at a half-frame boundary
  function automatic logic [SAMPLE_W-1:0] pick_word(input logic [2:0] fmt,
                                                   input logic [SAMPLE_W-1:0] hist,
                                                   input logic now_bit,
                                                   input logic [CNT_W-1:0] half_len);
    logic [SAMPLE_W-1:0] raw;
    case (fmt)
      FMT_LJ20: raw = (half_len >= 20) ? (hist >> (int'(half_len) - 20)) : hist;
      FMT_I2S:  raw = {hist[SAMPLE_W-2:0], now_bit};
      default:  raw = hist;
    endcase
    return sign_fill(raw, word_bits(fmt, half_len));
  endfunction
endpackage

// File: rtl/srx_edge_sync.sv
module srx_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bck_i,
  input  logic lr_i,
  input  logic sd_i,
  output logic bit_rise,
  output logic lr_o,
  output logic sd_o
);
  localparam int W = 3;

  for (genvar g = 0; g < STAGES; g++) begin : g_st
    logic [W-1:0] q;
    if (g == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= {bck_i, lr_i, sd_i};
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= g_st[g-1].q;
      end
    end
  end

  logic [W-1:0] last;
  logic         bck_d;
  assign last = g_st[STAGES-1].q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bck_d <= 1'b0;
    else        bck_d <= last[2];
  end

  assign bit_rise = last[2] & ~bck_d;
  assign lr_o     = last[1];
  assign sd_o     = last[0];
endmodule

// File: rtl/srx_half_framer.sv
module srx_half_framer
  import srx_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic [2:0]          fmt,
  input  logic                bit_rise,
  input  logic                lr_s,
  input  logic                sd_s,
  output logic                half_done,
  output logic                half_right,
  output logic                hw_vld,
  output logic                hw_right,
  output logic [SAMPLE_W-1:0] hw_word,
  output logic [CNT_W-1:0]    hw_len
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [SAMPLE_W-1:0] hist;
  logic                lr_prev;
  logic                primed;
  logic                in_half;
  logic [CNT_W-1:0]    cnt;
  logic                lr_edge;

  assign lr_edge    = bit_rise && primed && (lr_s != lr_prev);
  assign half_done  = lr_edge && in_half;
  // I2S carries left while the frame clock is low; justified formats while high
  assign half_right = (fmt == FMT_I2S) ? lr_prev : ~lr_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist     <= '0;
      lr_prev  <= 1'b0;
      primed   <= 1'b0;
      in_half  <= 1'b0;
      cnt      <= '0;
      hw_vld   <= 1'b0;
      hw_right <= 1'b0;
      hw_word  <= '0;
      hw_len   <= '0;
    end else begin
      hw_vld <= half_done;
      if (half_done) begin
        hw_word  <= pick_word(fmt, hist, sd_s, cnt);
        hw_right <= half_right;
        hw_len   <= cnt;
      end
      if (bit_rise) begin
        hist    <= {hist[SAMPLE_W-2:0], sd_s};
        lr_prev <= lr_s;
        primed  <= 1'b1;
        if (lr_edge) begin
          in_half <= 1'b1;
          cnt     <= CNT_W'(1);
        end else if (cnt != CNT_MAX) begin
          cnt <= cnt + CNT_W'(1);
        end
      end
    end
  end
endmodule

// File: rtl/srx_frame_pack.sv
module srx_frame_pack
  import srx_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic [2:0]          fmt,
  input  logic                hw_vld,
  input  logic                hw_right,
  input  logic [SAMPLE_W-1:0] hw_word,
  input  logic [CNT_W-1:0]    hw_len,
  output logic [SAMPLE_W-1:0] pcm_left,
  output logic [SAMPLE_W-1:0] pcm_right,
  output logic                pcm_valid,
  output logic                frame_err
);
  logic [SAMPLE_W-1:0] left_q;
  logic [CNT_W-1:0]    left_len;
  logic                have_left;
  logic [CNT_W:0]      total;

  assign total = {1'b0, left_len} + {1'b0, hw_len};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      left_q    <= '0;
      left_len  <= '0;
      have_left <= 1'b0;
      pcm_left  <= '0;
      pcm_right <= '0;
      pcm_valid <= 1'b0;
      frame_err <= 1'b0;
    end else begin
      pcm_valid <= 1'b0;
      if (hw_vld && !hw_right) begin
        left_q    <= hw_word;
        left_len  <= hw_len;
        have_left <= 1'b1;
      end else if (hw_vld && have_left) begin
        pcm_left  <= left_q;
        pcm_right <= hw_word;
        frame_err <= ~frame_len_ok(fmt, total);
        pcm_valid <= 1'b1;
        have_left <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/serial_audio_rx.sv
module serial_audio_rx
  import srx_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [2:0]          fmt_sel,
  input  logic                bck,
  input  logic                lrck,
  input  logic                sdin,
  output logic [SAMPLE_W-1:0] pcm_left,
  output logic [SAMPLE_W-1:0] pcm_right,
  output logic                pcm_valid,
  output logic                frame_err
);
  logic [2:0]          fmt_q;
  logic                bit_rise;
  logic                lr_s;
  logic                sd_s;
  logic                half_done;
  logic                half_right;
  logic                hw_vld;
  logic                hw_right;
  logic [SAMPLE_W-1:0] hw_word;
  logic [CNT_W-1:0]    hw_len;

  // format follows the pins only while reset is held
  always_ff @(posedge clk) begin
    if (!rst_n) fmt_q <= fmt_sel;
  end

  srx_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .bck_i(bck), .lr_i(lrck), .sd_i(sdin),
    .bit_rise(bit_rise), .lr_o(lr_s), .sd_o(sd_s)
  );

  srx_half_framer u_framer (
    .clk(clk), .rst_n(rst_n), .fmt(fmt_q), .bit_rise(bit_rise),
    .lr_s(lr_s), .sd_s(sd_s), .half_done(half_done), .half_right(half_right),
    .hw_vld(hw_vld), .hw_right(hw_right), .hw_word(hw_word), .hw_len(hw_len)
  );

  srx_frame_pack u_pack (
    .clk(clk), .rst_n(rst_n), .fmt(fmt_q), .hw_vld(hw_vld), .hw_right(hw_right),
    .hw_word(hw_word), .hw_len(hw_len), .pcm_left(pcm_left), .pcm_right(pcm_right),
    .pcm_valid(pcm_valid), .frame_err(frame_err)
  );
endmodule

// File: rtl/serial_audio_rx_chk.sv
module serial_audio_rx_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [2:0]  fmt_q,
  input logic        half_done,
  input logic        half_right,
  input logic        pcm_valid,
  input logic [23:0] pcm_left,
  input logic [23:0] pcm_right,
  input logic        frame_err
);
  AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    pcm_valid |=> !pcm_valid); // R9

  AST_OUT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !pcm_valid |-> ($stable(pcm_left) && $stable(pcm_right) && $stable(frame_err))); // R9

  AST_STROBE_AFTER_RIGHT: assert property (@(posedge clk) disable iff (!rst_n)
    pcm_valid |-> $past(half_done && half_right, 2)); // R9

  AST_SEXT_16: assert property (@(posedge clk) disable iff (!rst_n)
    (pcm_valid && fmt_q == 3'd0) |->
      (pcm_left[23:16] == {8{pcm_left[15]}} && pcm_right[23:16] == {8{pcm_right[15]}})); // R3

  AST_SEXT_20: assert property (@(posedge clk) disable iff (!rst_n)
    (pcm_valid && (fmt_q == 3'd1 || fmt_q == 3'd2)) |->
      (pcm_left[23:20] == {4{pcm_left[19]}} && pcm_right[23:20] == {4{pcm_right[19]}})); // R4
endmodule

bind serial_audio_rx serial_audio_rx_chk u_chk (
  .clk(clk), .rst_n(rst_n), .fmt_q(fmt_q), .half_done(half_done),
  .half_right(half_right), .pcm_valid(pcm_valid), .pcm_left(pcm_left),
  .pcm_right(pcm_right), .frame_err(frame_err)
);

// File: tb/serial_audio_rx_tb.sv
module serial_audio_rx_tb;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst_n = 1'b0;
  logic [2:0]  fmt_sel = 3'd0;
  logic        bck = 1'b0, lrck = 1'b0, sdin = 1'b0;
  logic [23:0] pcm_left, pcm_right;
  logic        pcm_valid, frame_err;

  serial_audio_rx u_dut (
    .clk(clk), .rst_n(rst_n), .fmt_sel(fmt_sel), .bck(bck), .lrck(lrck), .sdin(sdin),
    .pcm_left(pcm_left), .pcm_right(pcm_right), .pcm_valid(pcm_valid), .frame_err(frame_err)
  );

  int n_chk = 0, n_fail = 0;
  bit running = 0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // frame specs of the current run
  int          f_hl[$], f_hr[$];
  logic [23:0] f_vl[$], f_vr[$];
  // serial stream
  bit s_lr[$], s_sd[$];
  int s_end[$];
  // expectations
  logic [23:0] e_l[$], e_r[$];
  bit          e_err[$], e_dchk[$];
  string       e_req[$];
  int          front_age = 0;
  logic [23:0] last_l = '0, last_r = '0;
  bit          last_e = 0;
  int          cur_fmt = 0;

  function automatic int wbits(int f, int h);
    if (f == 0) return 16;
    if (f == 1 || f == 2) return 20;
    if (f == 3) return (h <= 16) ? 16 : 20;
    return 24;
  endfunction

  function automatic bit len_good(int f, int tot);
    if (f == 0) return tot == 32;
    if (f == 1 || f == 2) return tot == 40;
    if (f == 3) return tot == 32 || tot == 40;
    return tot == 48;
  endfunction

  function automatic logic [23:0] sx(logic [23:0] v, int w);
    logic [23:0] r;
    for (int k = 0; k < 24; k++) r[k] = (k < w) ? v[k] : v[w-1];
    return r;
  endfunction

  task automatic add_half(int f, bit lv, logic [23:0] v, int h, int mark);
    int w = wbits(f, h);
    for (int k = 0; k < h; k++) begin
      int p;
      bit b;
      p = (f == 2 || f == 3) ? k : k - (h - w);
      b = (p >= 0 && p < w) ? v[w-1-p] : 1'($urandom);
      s_lr.push_back(lv);
      s_sd.push_back(b);
      s_end.push_back(k == 0 ? mark : -1);
    end
  endtask

  task automatic add_frame(int hl, int hr);
    f_hl.push_back(hl); f_hr.push_back(hr);
    f_vl.push_back(24'($urandom)); f_vr.push_back(24'($urandom));
  endtask

  task automatic expect_frame(int id);
    int wl = wbits(cur_fmt, f_hl[id]);
    int wr = wbits(cur_fmt, f_hr[id]);
    bit dc;
    string rq;
    if (cur_fmt == 3) dc = (f_hl[id] == 16 || f_hl[id] == 20) && (f_hr[id] == 16 || f_hr[id] == 20);
    else              dc = (f_hl[id] >= wl) && (f_hr[id] >= wr);
    case (cur_fmt)
      0: rq = "R3"; 1: rq = "R4"; 2: rq = "R5"; 3: rq = "R6"; default: rq = "R7";
    endcase
    if (cur_fmt != 2 && cur_fmt != 3 && (f_hl[id] > wl || f_hr[id] > wr)) rq = "R8";
    e_l.push_back(sx(f_vl[id], wl));
    e_r.push_back(sx(f_vr[id], wr));
    e_err.push_back(!len_good(cur_fmt, f_hl[id] + f_hr[id]));
    e_dchk.push_back(dc);
    e_req.push_back(rq);
  endtask

  always @(negedge clk) begin
    if (running && rst_n) begin
      if (e_l.size() > 0) front_age++;
      if (pcm_valid) begin
        if (e_l.size() == 0) begin
          chk(0, "R11 or R9 unexpected strobe", 32'(pcm_valid), 32'd0);
        end else begin
          chk(frame_err == e_err[0], "R10 frame_err", 32'(frame_err), 32'(e_err[0]));
          if (e_dchk[0]) begin
            chk(pcm_left == e_l[0], {e_req[0], " left"}, 32'(pcm_left), 32'(e_l[0]));
            chk(pcm_right == e_r[0], {e_req[0], " right"}, 32'(pcm_right), 32'(e_r[0]));
          end
          void'(e_l.pop_front()); void'(e_r.pop_front()); void'(e_err.pop_front());
          void'(e_dchk.pop_front()); void'(e_req.pop_front());
          front_age = 0;
        end
        last_l = pcm_left; last_r = pcm_right; last_e = frame_err;
      end else begin
        chk(pcm_left == last_l && pcm_right == last_r && frame_err == last_e,
            "R9 hold", 32'(pcm_left), 32'(last_l));
        if (front_age > 6) begin
          chk(0, "R9 late strobe", 32'(front_age), 32'd6);
          void'(e_l.pop_front()); void'(e_r.pop_front()); void'(e_err.pop_front());
          void'(e_dchk.pop_front()); void'(e_req.pop_front());
          front_age = 0;
        end
      end
    end
  end

  task automatic play(int f, int late_fmt);
    bit ll;
    running = 0;
    rst_n = 1'b0;
    fmt_sel = 3'(f);
    bck = 0; lrck = 0; sdin = 0;
    repeat (5) @(negedge clk);
    chk(pcm_left == 0 && pcm_right == 0 && !pcm_valid && !frame_err,
        "R1 reset outputs", {pcm_left[7:0], pcm_right[7:0], 7'd0, pcm_valid, 7'd0, frame_err}, 32'd0);
    e_l.delete(); e_r.delete(); e_err.delete(); e_dchk.delete(); e_req.delete();
    last_l = '0; last_r = '0; last_e = 0; front_age = 0;
    cur_fmt = (f > 4) ? 4 : f;
    s_lr.delete(); s_sd.delete(); s_end.delete();
    ll = (cur_fmt == 3) ? 1'b0 : 1'b1;
    add_half(cur_fmt, ll, '0, 3, -1);   // partial left, no edge before it
    add_half(cur_fmt, !ll, '0, 16, -1); // right with no left before it
    for (int j = 0; j < f_hl.size(); j++) begin
      add_half(cur_fmt, ll, f_vl[j], f_hl[j], j - 1);
      add_half(cur_fmt, !ll, f_vr[j], f_hr[j], -1);
    end
    add_half(cur_fmt, ll, '0, 3, f_hl.size() - 1);
    if (cur_fmt == 3) begin
      s_sd.push_front(1'b0);
      void'(s_sd.pop_back());
    end
    @(negedge clk);
    rst_n = 1'b1;
    running = 1;
    @(negedge clk);
    if (late_fmt >= 0) fmt_sel = 3'(late_fmt); // R2: must be ignored
    for (int i = 0; i < s_lr.size(); i++) begin
      lrck = s_lr[i]; sdin = s_sd[i];
      repeat (4) @(negedge clk);
      bck = 1'b1;
      if (s_end[i] >= 0) expect_frame(s_end[i]);
      repeat (4) @(negedge clk);
      bck = 1'b0;
    end
    repeat (12) @(negedge clk);
    chk(e_l.size() == 0, "R9 missing strobes", 32'(e_l.size()), 32'd0);
    f_hl.delete(); f_hr.delete(); f_vl.delete(); f_vr.delete();
  endtask

  bit done = 0;

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    // R3 and R2: code 0 with a late change of the select pins
    for (int j = 0; j < 4; j++) add_frame(16, 16);
    play(0, 4);
    // R4, R8, R10
    add_frame(20, 20); add_frame(20, 20); add_frame(24, 24); add_frame(20, 20);
    play(1, -1);
    // R5: trailing bits in a long half are ignored
    add_frame(20, 20); add_frame(20, 20); add_frame(24, 24); add_frame(20, 20);
    play(2, -1);
    // R6: both word widths and a bad frame
    add_frame(16, 16); add_frame(16, 16); add_frame(20, 20); add_frame(20, 20);
    add_frame(24, 24); add_frame(16, 16);
    play(3, -1);
    // R7
    add_frame(24, 24); add_frame(24, 24); add_frame(24, 24); add_frame(20, 20); add_frame(24, 24);
    play(4, -1);
    add_frame(24, 24); add_frame(24, 24);
    play(6, -1);
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule